// File: doc/BRIEF.md
# Dual-Band Two-Digit Logarithmic Product Accumulator

This unit is the arithmetic core of a serial filterbank whose filter pairs mirror each other: a low-band filter and a high-band filter whose taps share magnitudes and differ only in sign pattern. Each input cycle it takes one data sample and one coefficient, both written as two logarithmic digits. Every digit carries a sign bit, an unsigned power-of-two exponent and a signed power-of-three exponent. It forms the four digit-by-digit products, merges them into one signed term and adds that term into a low-band running sum and a high-band running sum. When the mirror symmetry calls for it, the high-band sum receives the term negated.

Every digit has a single sign bit. A digit is zero when its power-of-three exponent holds the most negative code of its field. Each of the four product paths yields only a magnitude and a sign. Five add/subtract stages, three deep, merge the four products and feed both bands. Each stage picks add or subtract from the signs, so no stage negates a value on its own. A controller outside the unit supplies the samples and coefficients. It raises `start` on the first tap of each new output sample.

Top module: `lnsfb_dualband`

## Requirements
- R1: For a data digit (a_d, b_d) and a coefficient digit (a_c, b_c) that are both non-zero, with s = b_d + b_c in −15..15, the product magnitude is floor(T[s] · 2^(a_d+a_c) / 2^24). Here T[s] = 3^s · 2^24 for s ≥ 0 and T[s] = floor(2^24 / 3^(−s)) for s < 0.
- R2: A data digit whose 5-bit power-of-three exponent is −16 (binary 10000), or a coefficient digit whose 3-bit power-of-three exponent is −4 (binary 100), is zero. Every product that involves it contributes 0, whatever the sign bits say.
- R3: The sign of a product is the XOR of its data and coefficient sign bits, and a sign bit of 1 means negative.
- R4: The term added per valid cycle is the signed sum of the four products data digit i × coefficient digit j, with i and j each 0 or 1. In every packed field, digit 0 sits in the low bits.
- R5: A valid cycle with `start` low adds the term to the current low-band and high-band sums.
- R6: The high band receives the negated term when `sym_even` and `coef_odd` are equal. When they differ it receives the term unchanged.
- R7: `out_valid` equals `in_valid` delayed by one clock, and the sums show the effect of a valid cycle one clock later.
- R8: A cycle with `in_valid` low leaves both sums unchanged, even when `start` or the operand inputs change.
- R9: After reset, `out_valid` is 0 and both sums are 0.
- R10: A valid cycle with `start` high discards both previous sums and loads them with this cycle's band terms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are valid this cycle |
| start | input | 1 | First tap of a new output sample |
| sym_even | input | 1 | Symmetry kind of the filter pair |
| coef_odd | input | 1 | Lowest bit of the coefficient index |
| dat_sgn | input | 2 | Data digit sign bits |
| dat_pexp | input | 6 | Data power-of-two exponents, 3 bits per digit, unsigned |
| dat_qexp | input | 10 | Data power-of-three exponents, 5 bits per digit, signed |
| cof_sgn | input | 2 | Coefficient digit sign bits |
| cof_pexp | input | 6 | Coefficient power-of-two exponents, 3 bits per digit |
| cof_qexp | input | 6 | Coefficient power-of-three exponents, 3 bits per digit, signed |
| out_valid | output | 1 | Sums were updated on the last clock |
| acc_lo | output | 48 | Low-band running sum, two's complement |
| acc_hi | output | 48 | High-band running sum, two's complement |

## Verification
The in-line properties watch several rules on every cycle. They check that `out_valid` follows `in_valid` by one clock and that idle cycles leave both sums alone. On every fresh start, the high sum must equal the low sum or its negation according to the symmetry inputs. Fresh starts whose four products all carry the same sign must leave the low sum with that sign, and fresh starts whose digits are all zero-coded must leave both sums at zero. The exact magnitudes cannot be seen cycle by cycle, so only the bench scenarios show them. Those scenarios cover the exponent table at both ends of its range, mixed signs inside the tree, running accumulation across taps, and zero-coded digits that carry stray sign bits.

// File: rtl/lnsfb_pkg.sv
package lnsfb_pkg;

  // Fixed-point value of 3^s: integer powers above zero, reciprocal below.
  function automatic logic [63:0] qpow_entry(input int s, input int frac);
    logic [63:0] p;
    int n;
    n = (s < 0) ? -s : s;
    p = 64'd1;
    for (int k = 0; k < n; k++) p = p * 64'd3;
    if (s >= 0) return p << frac;
    return (64'd1 << frac) / p;
  endfunction

  // Mirror rule for the high band: negate when both controls agree.
  function automatic logic mirror_negate(input logic sym_even, input logic coef_odd);
    return ~(sym_even ^ coef_odd);
  endfunction

  // Shared add/subtract stage.
  function automatic logic signed [63:0] add_or_sub(input logic signed [63:0] x,
                                                    input logic signed [63:0] y,
                                                    input logic sub);
    return sub ? (x - y) : (x + y);
  endfunction

endpackage

// File: rtl/lnsfb_pp.sv
module lnsfb_pp #(
  parameter int PE_W  = 3,
  parameter int DQ_W  = 5,
  parameter int CQ_W  = 3,
  parameter int QSPAN = 15,
  parameter int FRAC  = 24,
  parameter int TAB_W = 48,
  parameter int PP_W  = 40
) (
  input  logic            d_s,
  input  logic [PE_W-1:0] d_a,
  input  logic [DQ_W-1:0] d_q,
  input  logic            c_s,
  input  logic [PE_W-1:0] c_a,
  input  logic [CQ_W-1:0] c_q,
  output logic            pp_s,
  output logic [PP_W-1:0] pp_mag,
  output logic            zero_op
);
  import lnsfb_pkg::*;

  localparam int NTAB   = 2 * QSPAN + 1;
  localparam int IDX_W  = $clog2(NTAB);
  localparam int WIDE_W = TAB_W + 2 * ((1 << PE_W) - 1);
  localparam int QS_W   = DQ_W + 1;

  logic [TAB_W-1:0] tab [NTAB];

  for (genvar k = 0; k < NTAB; k++) begin : g_tab
    localparam logic [63:0] ENTRY = qpow_entry(k - QSPAN, FRAC);
    assign tab[k] = ENTRY[TAB_W-1:0];
  end

  logic signed [QS_W-1:0] qsum;
  logic signed [QS_W:0]   qoff;
  logic                   in_range;
  logic [TAB_W-1:0]       tab_sel;
  logic [PE_W:0]          sa;
  logic [WIDE_W-1:0]      wide;

  assign zero_op  = (d_q == {1'b1, {(DQ_W-1){1'b0}}}) || (c_q == {1'b1, {(CQ_W-1){1'b0}}});
  assign qsum     = $signed({d_q[DQ_W-1], d_q}) + $signed({{(QS_W-CQ_W){c_q[CQ_W-1]}}, c_q});
  assign qoff     = $signed({qsum[QS_W-1], qsum}) + $signed((QS_W+1)'(QSPAN));
  assign in_range = (qoff >= 0) && (qoff <= $signed((QS_W+1)'(2 * QSPAN)));
  assign tab_sel  = in_range ? tab[qoff[IDX_W-1:0]] : '0;
  assign sa       = {1'b0, d_a} + {1'b0, c_a};
  assign wide     = WIDE_W'(tab_sel) << sa;

  assign pp_s   = d_s ^ c_s;
  assign pp_mag = (zero_op || !in_range) ? '0 : PP_W'(wide >> FRAC);

endmodule

// File: rtl/lnsfb_merge.sv
module lnsfb_merge #(
  parameter int PP_W  = 40,
  parameter int ACC_W = 48
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    start,
  input  logic                    neg_hi,
  input  logic [3:0]              pp_sgn,
  input  logic [4*PP_W-1:0]       pp_mag,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] acc_lo,
  output logic signed [ACC_W-1:0] acc_hi
);
  import lnsfb_pkg::*;

  logic signed [63:0] mx [4];
  for (genvar q = 0; q < 4; q++) begin : g_ext
    assign mx[q] = $signed(64'(pp_mag[q*PP_W +: PP_W]));
  end

  // Stage-select events, named for the checks.
  logic sub_pair0, sub_pair1, sub_quad, sub_lo, sub_hi;
  assign sub_pair0 = pp_sgn[0] ^ pp_sgn[1];
  assign sub_pair1 = pp_sgn[2] ^ pp_sgn[3];
  assign sub_quad  = pp_sgn[0] ^ pp_sgn[2];
  assign sub_lo    = pp_sgn[0];
  assign sub_hi    = pp_sgn[0] ^ neg_hi;

  logic signed [63:0] pair0, pair1, quad, base_lo, base_hi, nxt_lo, nxt_hi;
  assign pair0   = add_or_sub(mx[0], mx[1], sub_pair0);
  assign pair1   = add_or_sub(mx[2], mx[3], sub_pair1);
  assign quad    = add_or_sub(pair0, pair1, sub_quad);
  assign base_lo = start ? '0 : 64'(acc_lo);
  assign base_hi = start ? '0 : 64'(acc_hi);
  assign nxt_lo  = add_or_sub(base_lo, quad, sub_lo);
  assign nxt_hi  = add_or_sub(base_hi, quad, sub_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      acc_lo    <= '0;
      acc_hi    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        acc_lo <= nxt_lo[ACC_W-1:0];
        acc_hi <= nxt_hi[ACC_W-1:0];
      end
    end
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R7
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(acc_lo) && $stable(acc_hi)));
  // R6
  mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && start) |=> (acc_hi == ($past(neg_hi) ? -acc_lo : acc_lo)));
  // R3
  pos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && start && pp_sgn == 4'b0000) |=> !acc_lo[ACC_W-1]);
  // R3
  neg_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && start && pp_sgn == 4'b1111) |=> (acc_lo[ACC_W-1] || acc_lo == '0));

endmodule

// File: rtl/lnsfb_dualband.sv
module lnsfb_dualband #(
  parameter int PE_W  = 3,
  parameter int DQ_W  = 5,
  parameter int CQ_W  = 3,
  parameter int QSPAN = 15,
  parameter int FRAC  = 24,
  parameter int TAB_W = 48,
  parameter int PP_W  = 40,
  parameter int ACC_W = 48
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    start,
  input  logic                    sym_even,
  input  logic                    coef_odd,
  input  logic [1:0]              dat_sgn,
  input  logic [2*PE_W-1:0]       dat_pexp,
  input  logic [2*DQ_W-1:0]       dat_qexp,
  input  logic [1:0]              cof_sgn,
  input  logic [2*PE_W-1:0]       cof_pexp,
  input  logic [2*CQ_W-1:0]       cof_qexp,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] acc_lo,
  output logic signed [ACC_W-1:0] acc_hi
);
  import lnsfb_pkg::*;

  logic [3:0]        pp_sgn;
  logic [3:0]        zero_hit;
  logic [4*PP_W-1:0] pp_mag;
  logic              neg_hi;

  assign neg_hi = mirror_negate(sym_even, coef_odd);

  for (genvar i = 0; i < 2; i++) begin : g_dat
    for (genvar j = 0; j < 2; j++) begin : g_cof
      lnsfb_pp #(
        .PE_W(PE_W), .DQ_W(DQ_W), .CQ_W(CQ_W), .QSPAN(QSPAN),
        .FRAC(FRAC), .TAB_W(TAB_W), .PP_W(PP_W)
      ) u_pp (
        .d_s    (dat_sgn[i]),
        .d_a    (dat_pexp[i*PE_W +: PE_W]),
        .d_q    (dat_qexp[i*DQ_W +: DQ_W]),
        .c_s    (cof_sgn[j]),
        .c_a    (cof_pexp[j*PE_W +: PE_W]),
        .c_q    (cof_qexp[j*CQ_W +: CQ_W]),
        .pp_s   (pp_sgn[i*2+j]),
        .pp_mag (pp_mag[(i*2+j)*PP_W +: PP_W]),
        .zero_op(zero_hit[i*2+j])
      );
    end
  end

  lnsfb_merge #(.PP_W(PP_W), .ACC_W(ACC_W)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .start    (start),
    .neg_hi   (neg_hi),
    .pp_sgn   (pp_sgn),
    .pp_mag   (pp_mag),
    .out_valid(out_valid),
    .acc_lo   (acc_lo),
    .acc_hi   (acc_hi)
  );

  // R2
  zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && start && (&zero_hit)) |=> (acc_lo == '0 && acc_hi == '0));

endmodule

// File: tb/lnsfb_dualband_test.sv
module lnsfb_dualband_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, start = 1'b0, sym_even = 1'b0, coef_odd = 1'b0;
  logic [1:0] dat_sgn = '0, cof_sgn = '0;
  logic [5:0] dat_pexp = '0, cof_pexp = '0;
  logic [9:0] dat_qexp = '0;
  logic [5:0] cof_qexp = '0;
  logic out_valid;
  logic signed [47:0] acc_lo, acc_hi;

  int n_total = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  lnsfb_dualband uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .start(start),
    .sym_even(sym_even), .coef_odd(coef_odd),
    .dat_sgn(dat_sgn), .dat_pexp(dat_pexp), .dat_qexp(dat_qexp),
    .cof_sgn(cof_sgn), .cof_pexp(cof_pexp), .cof_qexp(cof_qexp),
    .out_valid(out_valid), .acc_lo(acc_lo), .acc_hi(acc_hi)
  );

  // {start, sym_even, coef_odd, dsgn, dpexp(d1,d0), dqexp(d1,d0), csgn, cpexp(d1,d0), cqexp(d1,d0)}
  localparam logic [34:0] VEC [8] = '{
    {1'b1, 1'b1, 1'b0, 2'b00, 3'd1, 3'd2, 5'sd0, 5'sd1, 2'b00, 3'd0, 3'd1, 3'sd0, 3'sd0},
    {1'b0, 1'b1, 1'b1, 2'b01, 3'd3, 3'd0, -5'sd2, 5'sd2, 2'b10, 3'd2, 3'd2, 3'sd1, -3'sd1},
    {1'b0, 1'b0, 1'b0, 2'b11, 3'd1, 3'd1, 5'sd3, 5'b10000, 2'b01, 3'd1, 3'd0, 3'sd2, -3'sd1},
    {1'b0, 1'b1, 1'b0, 2'b10, 3'd2, 3'd2, -5'sd5, 5'sd4, 2'b00, 3'd3, 3'd1, 3'b100, 3'sd3},
    {1'b1, 1'b0, 1'b0, 2'b11, 3'd0, 3'd4, 5'sd12, -5'sd12, 2'b11, 3'd2, 3'd0, 3'sd3, -3'sd3},
    {1'b0, 1'b0, 1'b1, 2'b00, 3'd5, 3'd6, 5'sd7, -5'sd7, 2'b01, 3'd4, 3'd2, -3'sd2, 3'sd2},
    {1'b1, 1'b1, 1'b1, 2'b00, 3'd7, 3'd7, 5'sd12, 5'sd12, 2'b00, 3'd7, 3'd7, 3'sd3, 3'sd3},
    {1'b1, 1'b0, 1'b1, 2'b11, 3'd7, 3'd7, 5'b10000, 5'b10000, 2'b11, 3'd0, 3'd0, 3'sd0, 3'sd0}
  };

  string tagv [8] = '{"R1 R4", "R3 R5 R6", "R2", "R2", "R10 R6", "R5", "R1", "R2 R10"};

  // Bench view of one digit product.
  function automatic longint part(input logic ds, input logic [2:0] da, input logic [4:0] db,
                                  input logic cs, input logic [2:0] ca, input logic [2:0] cb);
    longint t;
    longint p;
    int s;
    if (db == 5'b10000 || cb == 3'b100) return 0;
    s = int'($signed(db)) + int'($signed(cb));
    p = 1;
    for (int k = 0; k < ((s < 0) ? -s : s); k++) p = p * 3;
    if (s >= 0) t = p * 64'sd16777216;
    else t = 64'sd16777216 / p;
    t = (t * (64'sd1 <<< (int'(da) + int'(ca)))) / 64'sd16777216;
    return (ds ^ cs) ? -t : t;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [34:0] v);
    start    = v[34];
    sym_even = v[33];
    coef_odd = v[32];
    dat_sgn  = v[31:30];
    dat_pexp = v[29:24];
    dat_qexp = v[23:14];
    cof_sgn  = v[13:12];
    cof_pexp = v[11:6];
    cof_qexp = v[5:0];
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    n_total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    longint mlo, mhi, term;
    logic [34:0] v;
    mlo = 0;
    mhi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 out_valid after reset", longint'(out_valid), 0);
    check("R9 acc_lo after reset", longint'(acc_lo), 0);
    check("R9 acc_hi after reset", longint'(acc_hi), 0);

    for (int n = 0; n < 8; n++) begin
      v = VEC[n];
      drive(v);
      in_valid = 1'b1;
      term = 0;
      for (int i = 0; i < 2; i++)
        for (int j = 0; j < 2; j++)
          term += part(v[30+i], v[24+3*i +: 3], v[14+5*i +: 5],
                       v[12+j], v[6+3*j +: 3], v[3*j +: 3]);
      if (v[34]) begin
        mlo = 0;
        mhi = 0;
      end
      mlo += term;
      mhi += (v[33] == v[32]) ? -term : term;
      @(posedge clk);
      @(negedge clk);
      check({tagv[n], " R7 out_valid"}, longint'(out_valid), 1);
      check({tagv[n], " acc_lo"}, longint'(acc_lo), mlo);
      check({tagv[n], " acc_hi"}, longint'(acc_hi), mhi);
    end

    // Idle cycle with start and operands changed: nothing moves.
    in_valid = 1'b0;
    drive(VEC[6]);
    @(posedge clk);
    @(negedge clk);
    check("R7 out_valid idle", longint'(out_valid), 0);
    check("R8 acc_lo idle", longint'(acc_lo), mlo);
    check("R8 acc_hi idle", longint'(acc_hi), mhi);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule